// File: doc/BRIEF.md
# LED Row Refresh and Brightness Controller

This block runs the multiplexed scan of a 20-column by 8-row LED matrix from a latched dot image. A display clock steps a frame of 512 ticks. The frame holds eight row slots of 64 ticks each, taken in ascending row order. Inside a slot, the selected row is driven for the first 60 ticks at most, and the last 4 ticks are always dark so the drivers can settle before the next row. A 4-bit brightness code picks the number of lit ticks per row from a fixed, nonlinear sixteen-step curve. A 2-bit peak-drive code is translated into an ordinal current-level code for the analog current sources, which sit outside this block.

The display clock comes from one of two tick inputs. One is an internal oscillator tick. The other is an external oscillator tick, which may optionally be divided by eight; the divider never acts on the internal tick. A sleep control freezes the scan position and forces every driver off. A blanking input forces every driver off at once and may be toggled as a dimming control. Row 0 carries no LEDs, so it never enables a column.

Top module: `led_refresh_ctrl`

## Requirements
- R1: The scan advances one step per display tick. Rows are visited 0,1,...,7 and then wrap, with 64 ticks per row, so one frame is 512 ticks. With one display tick per clock, any given row becomes selected again 512 clocks after it was last selected.
- R2: In the last 4 ticks of every row slot, `row_sel` and `col_en` are all zero. Outside those ticks, while awake and not blanked, `row_sel` is one-hot on the current row for 60 ticks per slot.
- R3: Per row slot, columns are lit only while the tick count in the slot (from 0) is below the on-count for `pwm_code`. The on-counts for codes 0..15 are 0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60.
- R4: Column c is enabled during row r only if `dot_bits[c*8+r]` is 1.
- R5: While row 0 is selected, no column is ever enabled.
- R6: `cur_level` takes the following values one clock after `cur_code` changes: 2'b10→0, 2'b01→1, 2'b00→2, 2'b11→3. The reset value is 2.
- R7: While `wake` is 0, all outputs `row_sel` and `col_en` are zero and the scan position holds. When `wake` returns to 1, the scan resumes from the held position.
- R8: When `prescale_en` is 1 and the external tick is selected, one display tick occurs per 8 external ticks, so a frame takes 4096 external ticks. With the internal tick selected, `prescale_en` has no effect.
- R9: While `blank_in` is 1, `row_sel` and `col_en` are zero in the same cycle.
- R10: With `osc_sel`=1 only `int_tick` advances the scan. With `osc_sel`=0 only `ext_tick` advances it.
- R11: The reset state is row 0, tick 0: `row_sel`=8'h01 (awake, not blanked), `col_en`=0, `cur_level`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_bits | input | 160 | Latched dot image, bit c*8+r is column c, row r |
| pwm_code | input | 4 | Brightness on-time code |
| cur_code | input | 2 | Peak drive code |
| wake | input | 1 | 1 = normal, 0 = sleep |
| prescale_en | input | 1 | Divide the external tick by 8 |
| osc_sel | input | 1 | 1 = internal tick, 0 = external tick |
| int_tick | input | 1 | Internal oscillator tick |
| ext_tick | input | 1 | External oscillator tick |
| blank_in | input | 1 | Force all drivers off |
| row_sel | output | 8 | One-hot row driver enable |
| col_en | output | 20 | Column driver enables |
| cur_level | output | 2 | Ordinal drive level, 0 = lowest |

## Verification
A source tick passes through one register and then moves the scan counter, so the scan moves two clocks after the tick. `row_sel` and `col_en` are combinational from the scan counter and the static inputs. Blank and sleep therefore act on the outputs in the same cycle, and the checks sample them at the falling edge right after the input changes. The per-row lit counts and the frame periods are totals taken over whole 512-tick windows or between successive rising edges of one row select, so the scan phase does not affect them. `cur_level` has one register of latency, and the checks read it two edges after the change.

// File: rtl/led_refresh_pkg.sv
package led_refresh_pkg;

  // Lit ticks per row slot, indexed by the brightness code
  function automatic logic [5:0] pwm_on_ticks(input logic [3:0] code);
    logic [5:0] v;
    case (code)
      4'd0:    v = 6'd0;
      4'd1:    v = 6'd1;
      4'd2:    v = 6'd2;
      4'd3:    v = 6'd3;
      4'd4:    v = 6'd4;
      4'd5:    v = 6'd5;
      4'd6:    v = 6'd7;
      4'd7:    v = 6'd9;
      4'd8:    v = 6'd11;
      4'd9:    v = 6'd14;
      4'd10:   v = 6'd18;
      4'd11:   v = 6'd22;
      4'd12:   v = 6'd28;
      4'd13:   v = 6'd36;
      4'd14:   v = 6'd48;
      default: v = 6'd60;
    endcase
    return v;
  endfunction

  // Peak drive code to ordinal level (0 = weakest)
  function automatic logic [1:0] drive_level(input logic [1:0] code);
    logic [1:0] v;
    case (code)
      2'b10:   v = 2'd0;
      2'b01:   v = 2'd1;
      2'b00:   v = 2'd2;
      default: v = 2'd3;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int PRESCALE_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_sel,
  input  logic int_tick,
  input  logic ext_tick,
  input  logic prescale_en,
  input  logic wake,
  output logic disp_tick
);
  localparam int PW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE_DIV - 1);

  logic [PW-1:0] pre_cnt_q, pre_cnt_d;
  logic          tick_q, tick_d;
  logic          pre_run, ext_path, src_tick;

  always_comb begin
    pre_run  = wake && !osc_sel && prescale_en && ext_tick;
    ext_path = prescale_en ? (ext_tick && (pre_cnt_q == PRE_LAST)) : ext_tick;
    src_tick = osc_sel ? int_tick : ext_path;
    tick_d   = wake && src_tick;
    pre_cnt_d = pre_cnt_q;
    if (pre_run) begin
      if (pre_cnt_q == PRE_LAST) pre_cnt_d = '0;
      else                       pre_cnt_d = pre_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      tick_q    <= 1'b0;
    end else begin
      pre_cnt_q <= pre_cnt_d;
      tick_q    <= tick_d;
    end
  end

  assign disp_tick = tick_q;

endmodule

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
  parameter int NUM_ROWS = 8,
  parameter int SLOT_CYC = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  output logic [$clog2(NUM_ROWS)-1:0] row_idx,
  output logic [$clog2(SLOT_CYC)-1:0] slot_idx
);
  localparam int RW = $clog2(NUM_ROWS);
  localparam int SW = $clog2(SLOT_CYC);
  localparam logic [RW-1:0] ROW_LAST  = RW'(NUM_ROWS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYC - 1);

  logic [RW-1:0] row_q, row_d;
  logic [SW-1:0] slot_q, slot_d;

  always_comb begin
    row_d  = row_q;
    slot_d = slot_q;
    if (adv) begin
      if (slot_q == SLOT_LAST) begin
        slot_d = '0;
        row_d  = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        slot_d = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      slot_q <= '0;
    end else begin
      row_q  <= row_d;
      slot_q <= slot_d;
    end
  end

  assign row_idx  = row_q;
  assign slot_idx = slot_q;

endmodule

// File: rtl/led_col_driver.sv
module led_col_driver
  import led_refresh_pkg::*;
#(
  parameter int NUM_COLS  = 20,
  parameter int NUM_ROWS  = 8,
  parameter int SLOT_CYC  = 64,
  parameter int BLANK_CYC = 4
) (
  input  logic [$clog2(NUM_ROWS)-1:0]  row_idx,
  input  logic [$clog2(SLOT_CYC)-1:0]  slot_idx,
  input  logic [NUM_COLS*NUM_ROWS-1:0] dot_bits,
  input  logic [3:0]                   pwm_code,
  input  logic                         wake,
  input  logic                         blank_in,
  output logic [NUM_ROWS-1:0]          row_sel,
  output logic [NUM_COLS-1:0]          col_en
);
  localparam int LIT_MAX = SLOT_CYC - BLANK_CYC;

  logic drive_ok, in_window, in_pwm, row_has_leds;

  always_comb begin
    drive_ok     = wake && !blank_in;
    in_window    = int'(slot_idx) < LIT_MAX;
    in_pwm       = int'(slot_idx) < int'(pwm_on_ticks(pwm_code));
    row_has_leds = (row_idx != '0);
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_sel[r] = drive_ok && in_window && (int'(row_idx) == r);
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [NUM_ROWS-1:0] col_dots;
    assign col_dots  = dot_bits[c*NUM_ROWS +: NUM_ROWS];
    assign col_en[c] = drive_ok && in_window && in_pwm && row_has_leds
                       && col_dots[row_idx];
  end

endmodule

// File: rtl/led_refresh_ctrl.sv
module led_refresh_ctrl
  import led_refresh_pkg::*;
#(
  parameter int NUM_COLS     = 20,
  parameter int NUM_ROWS     = 8,
  parameter int SLOT_CYC     = 64,
  parameter int BLANK_CYC    = 4,
  parameter int PRESCALE_DIV = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_COLS*NUM_ROWS-1:0] dot_bits,
  input  logic [3:0]                   pwm_code,
  input  logic [1:0]                   cur_code,
  input  logic                         wake,
  input  logic                         prescale_en,
  input  logic                         osc_sel,
  input  logic                         int_tick,
  input  logic                         ext_tick,
  input  logic                         blank_in,
  output logic [NUM_ROWS-1:0]          row_sel,
  output logic [NUM_COLS-1:0]          col_en,
  output logic [1:0]                   cur_level
);
  localparam int RW = $clog2(NUM_ROWS);
  localparam int SW = $clog2(SLOT_CYC);

  logic          disp_tick;
  logic          scan_adv;
  logic [RW-1:0] row_idx;
  logic [SW-1:0] slot_idx;
  logic [1:0]    lvl_q, lvl_d;

  led_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV)) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_sel     (osc_sel),
    .int_tick    (int_tick),
    .ext_tick    (ext_tick),
    .prescale_en (prescale_en),
    .wake        (wake),
    .disp_tick   (disp_tick)
  );

  assign scan_adv = disp_tick && wake;

  led_scan_timer #(.NUM_ROWS(NUM_ROWS), .SLOT_CYC(SLOT_CYC)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (scan_adv),
    .row_idx  (row_idx),
    .slot_idx (slot_idx)
  );

  led_col_driver #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS),
    .SLOT_CYC (SLOT_CYC),
    .BLANK_CYC(BLANK_CYC)
  ) u_drv (
    .row_idx  (row_idx),
    .slot_idx (slot_idx),
    .dot_bits (dot_bits),
    .pwm_code (pwm_code),
    .wake     (wake),
    .blank_in (blank_in),
    .row_sel  (row_sel),
    .col_en   (col_en)
  );

  always_comb lvl_d = drive_level(cur_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 2'd2;
    else        lvl_q <= lvl_d;
  end

  assign cur_level = lvl_q;

endmodule

// File: rtl/led_refresh_ctrl_chk.sv
module led_refresh_ctrl_chk #(
  parameter int NUM_COLS  = 20,
  parameter int NUM_ROWS  = 8,
  parameter int SLOT_CYC  = 64,
  parameter int BLANK_CYC = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wake,
  input logic                        blank_in,
  input logic [NUM_ROWS-1:0]         row_sel,
  input logic [NUM_COLS-1:0]         col_en,
  input logic [$clog2(NUM_ROWS)-1:0] row_idx,
  input logic [$clog2(SLOT_CYC)-1:0] slot_idx
);
  localparam int SW = $clog2(SLOT_CYC);

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel)); // R1

  AST_ROW_TRACKS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel != '0) |-> row_sel[row_idx]); // R1

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != $past(slot_idx)) |-> (slot_idx == SW'($past(slot_idx) + 1'b1))); // R1

  AST_TAIL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_idx) >= SLOT_CYC - BLANK_CYC) |-> (row_sel == '0 && col_en == '0)); // R2

  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (col_en != '0) |-> (row_sel != '0)); // R4

  AST_ROW0_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    row_sel[0] |-> (col_en == '0)); // R5

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |-> (row_sel == '0 && col_en == '0)); // R7

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |=> ($stable(slot_idx) && $stable(row_idx))); // R7

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    blank_in |-> (row_sel == '0 && col_en == '0)); // R9

endmodule

bind led_refresh_ctrl led_refresh_ctrl_chk #(
  .NUM_COLS (NUM_COLS),
  .NUM_ROWS (NUM_ROWS),
  .SLOT_CYC (SLOT_CYC),
  .BLANK_CYC(BLANK_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wake     (wake),
  .blank_in (blank_in),
  .row_sel  (row_sel),
  .col_en   (col_en),
  .row_idx  (row_idx),
  .slot_idx (slot_idx)
);

// File: tb/led_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module led_refresh_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [159:0] dot_bits;
  logic [3:0]   pwm_code;
  logic [1:0]   cur_code;
  logic         wake, prescale_en, osc_sel, int_tick, ext_tick, blank_in;
  logic [7:0]   row_sel;
  logic [19:0]  col_en;
  logic [1:0]   cur_level;

  int total = 0, bad = 0;
  int lit_cnt[8], sel_cnt[8];
  int pat_bad, ord_bad;
  bit done = 1'b0;

  always #10 clk = ~clk;

  led_refresh_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dot_bits(dot_bits), .pwm_code(pwm_code),
    .cur_code(cur_code), .wake(wake), .prescale_en(prescale_en),
    .osc_sel(osc_sel), .int_tick(int_tick), .ext_tick(ext_tick),
    .blank_in(blank_in), .row_sel(row_sel), .col_en(col_en),
    .cur_level(cur_level)
  );

  function automatic int exp_on(input int code);
    case (code)
      0: return 0;   1: return 1;   2: return 2;   3: return 3;
      4: return 4;   5: return 5;   6: return 7;   7: return 9;
      8: return 11;  9: return 14;  10: return 18; 11: return 22;
      12: return 28; 13: return 36; 14: return 48; default: return 60;
    endcase
  endfunction

  function automatic int exp_level(input logic [1:0] code);
    case (code)
      2'b10: return 0;
      2'b01: return 1;
      2'b00: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [19:0] exp_cols(input int r);
    logic [19:0] v;
    for (int c = 0; c < 20; c++) v[c] = (r != 0) && dot_bits[c*8 + r];
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Count one 512-clock window; optional blank toggling and pattern check
  task automatic scan_frame(input bit check_pat, input bit toggle_blank);
    int last = -1;
    for (int r = 0; r < 8; r++) begin lit_cnt[r] = 0; sel_cnt[r] = 0; end
    pat_bad = 0; ord_bad = 0;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      for (int r = 0; r < 8; r++) begin
        if (row_sel[r]) begin
          sel_cnt[r]++;
          if (col_en != '0) lit_cnt[r]++;
          if (check_pat && col_en != exp_cols(r)) pat_bad++;
          if (last >= 0 && r != last && r != (last + 1) % 8) ord_bad++;
          last = r;
        end
      end
      if (toggle_blank) blank_in = ~blank_in;
    end
    blank_in = 1'b0;
  endtask

  task automatic measure_period(output int p);
    logic prev;
    int   guard = 0;
    p = -1;
    prev = 1'b1;
    while (guard < 10000) begin
      @(negedge clk); guard++;
      if (row_sel[1] && !prev) break;
      prev = row_sel[1];
    end
    p = 0;
    prev = 1'b1;
    while (guard < 10000) begin
      @(negedge clk); guard++; p++;
      if (row_sel[1] && !prev) return;
      prev = row_sel[1];
    end
    p = -1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p;
    logic [7:0] held;
    int nz;
    rst_n = 1'b0; dot_bits = '1; pwm_code = 4'd15; cur_code = 2'b00;
    wake = 1'b1; prescale_en = 1'b0; osc_sel = 1'b1; int_tick = 1'b1;
    ext_tick = 1'b0; blank_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 row_sel", row_sel, 8'h01);
    chk("R11 col_en", col_en, 0);
    chk("R11 cur_level", cur_level, 2);
    rst_n = 1'b1;

    // R6 drive level mapping
    for (int c = 0; c < 4; c++) begin
      cur_code = 2'(c);
      repeat (2) @(negedge clk);
      chk("R6 cur_level", cur_level, exp_level(2'(c)));
    end

    // R3 / R2 / R5 sweep of all brightness codes, all dots on
    for (int code = 0; code < 16; code++) begin
      pwm_code = 4'(code);
      scan_frame(1'b0, 1'b0);
      for (int r = 0; r < 8; r++) begin
        chk(r == 0 ? "R5 row0 lit" : "R3 lit ticks", lit_cnt[r], r == 0 ? 0 : exp_on(code));
        chk("R2 row select ticks", sel_cnt[r], 60);
      end
    end

    // R4 column pattern and R1 row order
    for (int c = 0; c < 20; c++)
      for (int r = 0; r < 8; r++) dot_bits[c*8 + r] = ((c * 3 + r) % 4) != 0;
    pwm_code = 4'd15;
    scan_frame(1'b1, 1'b0);
    chk("R4 column pattern mismatches", pat_bad, 0);
    chk("R1 row order errors", ord_bad, 0);
    dot_bits = '1;

    // R1 / R8 / R10 frame periods
    measure_period(p); chk("R1 internal period", p, 512);
    prescale_en = 1'b1;
    measure_period(p); chk("R8 internal period unaffected by divider", p, 512);
    osc_sel = 1'b0; int_tick = 1'b0; ext_tick = 1'b1; prescale_en = 1'b0;
    measure_period(p); chk("R10 external period", p, 512);
    prescale_en = 1'b1;
    measure_period(p); chk("R8 external divided period", p, 4096);
    prescale_en = 1'b0; ext_tick = 1'b0; int_tick = 1'b1;
    @(negedge clk); @(negedge clk);
    held = row_sel; nz = 0;
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (row_sel != held) nz++; end
    chk("R10 internal tick ignored when external selected", nz, 0);
    osc_sel = 1'b1;

    // R9 blanking
    while (!row_sel[2]) @(negedge clk);
    blank_in = 1'b1; #1;
    chk("R9 blank row_sel", row_sel, 0);
    chk("R9 blank col_en", col_en, 0);
    @(negedge clk);
    scan_frame(1'b0, 1'b1);
    for (int r = 1; r < 8; r++) chk("R9 toggled blank lit ticks", lit_cnt[r], 30);
    scan_frame(1'b0, 1'b0);
    chk("R9 lit after blank release", lit_cnt[2], 60);

    // R7 sleep: outputs off, position held, scan resumes
    while (!row_sel[4]) @(negedge clk);
    repeat (5) @(negedge clk);
    held = row_sel;
    wake = 1'b0; nz = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (row_sel != 0 || col_en != 0) nz++;
    end
    chk("R7 outputs off in sleep", nz, 0);
    wake = 1'b1; #1;
    chk("R7 position held over sleep", row_sel, held);
    @(negedge clk);
    measure_period(p); chk("R7 period after wake", p, 512);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule